// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block carries out single-register reads and writes to an external display controller. It uses a three-wire link: an active-high chip enable, a serial clock that idles low, and one data line shared by both directions. The host hands over one request at a time. A request carries a direction flag, a 6-bit register address and, for writes, one data byte. The block serialises the request into a frame of exactly 16 clock pulses: six address bits, one direction bit, one turnaround pulse and eight data bits. It then keeps the enable low for a minimum recovery time and reports completion with a single-cycle response carrying the byte read back.

All serial timing comes from the system clock. The data setup time, clock-high time, clock-low time and enable-low recovery time are parameters given in nanoseconds. Each is converted to system-clock cycles by rounding up. The shared data pad is modelled as three signals: a driven value, an output enable and a sampled input.

The request side is a valid/ready handshake. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no frame is in progress. The host may hold `req_valid` for as long as it wants, and its fields must stay steady until the handshake. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `tw3_reg_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, the chip enable and serial clock are low, the data line is driven (output enable high) with value 0, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. In the next cycle the chip enable is high and `req_ready` is low. `req_ready` stays low until the response cycle. A request presented while `req_ready` is low has no effect on the frame in progress or on later frames.
- R3: The first six pulses carry the address, most significant bit first. The seventh pulse carries the direction bit: 1 for a read, 0 for a write.
- R4: The eighth pulse is a turnaround pulse with the data value 0. On a read, the output enable drops when that pulse's setup interval begins and stays low through all eight data pulses. On a write, it stays high for the whole frame.
- R5: On a write, pulses 9 to 16 drive the write byte, bit 7 first.
- R6: On a read, the data input is sampled at the system-clock edge where the serial clock rises for each of pulses 9 to 16. The first sample becomes bit 7 of `rsp_rdata`. A write frame returns `rsp_rdata` = 0.
- R7: Every pulse consists of S cycles with the clock low and data presented, then H cycles high, then L cycles low. S, H and L are the setup, high and low nanosecond minimums divided by the clock period and rounded up. A frame has exactly 16 pulses.
- R8: In the cycle after the last pulse's low interval ends, the chip enable falls, the data line is driven to 0 with output enable high, and this holds for G cycles. G is the recovery minimum in cycles, rounded up.
- R9: `rsp_valid` is high for exactly one cycle, the first cycle after the recovery interval. `req_ready` is high in that same cycle, so a new request can be accepted there.
- R10: The driven data value does not change while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read (0 after a write) |
| ser_en | output | 1 | Chip enable, active high |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dout | output | 1 | Value driven onto the data pad |
| ser_doe | output | 1 | Data pad output enable |
| ser_din | input | 1 | Value sampled from the data pad |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. This is the only point where the response and request sides meet. The bench provokes it by queuing a second request while a frame is running and holding `req_valid` high until the response cycle. It then checks three things: the response byte belongs to the finished frame, the chip enable rises in the very next cycle, and the new frame's address and data match the queued request rather than the one just answered. A stray request held high in mid-frame is also checked cycle by cycle against the reference, and a later read of the stray address shows it was never acted on.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_GAP
  } phase_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tw3_phase_timer.sv
// Down-counter that times one phase; done_o marks the last cycle of the phase.
module tw3_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/tw3_frame_shift.sv
// Outgoing frame shifter (MSB presented first) and read-byte capture register.
module tw3_frame_shift #(
  parameter int NBITS  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NBITS-1:0]  frame_i,
  input  logic              advance_i,
  input  logic              capture_i,
  input  logic              sdi_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [NBITS-1:0]  tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= frame_i;
    end else if (advance_i) begin
      tx_q <= {tx_q[NBITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load_i) begin
      rx_q <= '0;
    end else if (capture_i) begin
      rx_q <= {rx_q[DATA_W-2:0], sdi_i};
    end
  end

  assign bit_o   = tx_q[NBITS-1];
  assign rdata_o = rx_q;

endmodule

// File: rtl/tw3_reg_master.sv
module tw3_reg_master
  import tw3_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int SETUP_NS = 150,
  parameter int HIGH_NS  = 160,
  parameter int LOW_NS   = 160,
  parameter int GAP_NS   = 1000,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ser_en,
  output logic              ser_clk,
  output logic              ser_dout,
  output logic              ser_doe,
  input  logic              ser_din
);

  localparam int S_CYC   = ceil_div(SETUP_NS, CLK_NS);
  localparam int H_CYC   = ceil_div(HIGH_NS, CLK_NS);
  localparam int L_CYC   = ceil_div(LOW_NS, CLK_NS);
  localparam int G_CYC   = ceil_div(GAP_NS, CLK_NS);
  localparam int MAX_CYC = max2(max2(S_CYC, H_CYC), max2(L_CYC, G_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int NBITS   = ADDR_W + 2 + DATA_W;
  localparam int IDX_W   = $clog2(NBITS);

  localparam logic [CNT_W-1:0] S_LD = CNT_W'(S_CYC - 1);
  localparam logic [CNT_W-1:0] H_LD = CNT_W'(H_CYC - 1);
  localparam logic [CNT_W-1:0] L_LD = CNT_W'(L_CYC - 1);
  localparam logic [CNT_W-1:0] G_LD = CNT_W'(G_CYC - 1);

  localparam logic [IDX_W-1:0] TURN_I  = IDX_W'(ADDR_W + 1);
  localparam logic [IDX_W-1:0] DATA0_I = IDX_W'(ADDR_W + 2);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(NBITS - 1);

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q;
  logic             rd_q;
  logic             rsp_q;

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_done;
  logic             accept;
  logic             advance;
  logic             capture;
  logic             cur_bit;
  logic [NBITS-1:0] frame_word;
  logic             in_frame;
  logic             released;

  assign accept     = (ph_q == PH_IDLE) && req_valid;
  assign frame_word = {req_addr, ~req_write, 1'b0,
                       (req_write ? req_wdata : {DATA_W{1'b0}})};

  // Phase sequencing: setup -> high -> low per pulse, then recovery gap.
  always_comb begin
    ph_d    = ph_q;
    t_load  = 1'b0;
    t_val   = '0;
    advance = 1'b0;
    capture = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          ph_d   = PH_SETUP;
          t_load = 1'b1;
          t_val  = S_LD;
        end
      end
      PH_SETUP: begin
        if (t_done) begin
          ph_d    = PH_HIGH;
          t_load  = 1'b1;
          t_val   = H_LD;
          capture = rd_q && (idx_q >= DATA0_I);
        end
      end
      PH_HIGH: begin
        if (t_done) begin
          ph_d   = PH_LOW;
          t_load = 1'b1;
          t_val  = L_LD;
        end
      end
      PH_LOW: begin
        if (t_done) begin
          t_load = 1'b1;
          if (idx_q == LAST_I) begin
            ph_d  = PH_GAP;
            t_val = G_LD;
          end else begin
            ph_d    = PH_SETUP;
            t_val   = S_LD;
            advance = 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (t_done) begin
          ph_d = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      rd_q  <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rsp_q <= (ph_q == PH_GAP) && t_done;
      if (accept) begin
        idx_q <= '0;
        rd_q  <= ~req_write;
      end else if (advance) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  tw3_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (t_load),
    .load_val_i(t_val),
    .done_o    (t_done)
  );

  tw3_frame_shift #(
    .NBITS (NBITS),
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .frame_i  (frame_word),
    .advance_i(advance),
    .capture_i(capture),
    .sdi_i    (ser_din),
    .bit_o    (cur_bit),
    .rdata_o  (rsp_rdata)
  );

  assign in_frame  = (ph_q == PH_SETUP) || (ph_q == PH_HIGH) || (ph_q == PH_LOW);
  assign released  = in_frame && rd_q && (idx_q >= TURN_I);
  assign ser_en    = in_frame;
  assign ser_clk   = (ph_q == PH_HIGH);
  assign ser_doe   = ~released;
  assign ser_dout  = in_frame && !released && cur_bit;
  assign req_ready = (ph_q == PH_IDLE);
  assign rsp_valid = rsp_q;

  // R7
  clk_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> ser_en);

  // R10
  dout_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !req_ready);

  // R4
  release_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_doe |-> ser_en);

  // R6
  capture_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !ser_doe);

  // R8
  enable_fall_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_en) |-> (!ser_dout && ser_doe && !ser_clk));

  // R9
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

endmodule

// File: tb/tb_tw3_reg_master.sv
module tb_tw3_reg_master;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_NS = 5;
  localparam int S = 30;
  localparam int H = 32;
  localparam int L = 32;
  localparam int G = 200;
  localparam int P = S + H + L;
  localparam int FRAME = 16 * P + G;
  localparam int WATCHDOG = 120000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, ser_en, ser_clk, ser_dout, ser_doe;
  logic [7:0] rsp_rdata;
  logic       ser_din = 1'b0;

  always #2.5ns clk = ~clk;

  tw3_reg_master #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_dout(ser_dout),
    .ser_doe(ser_doe), .ser_din(ser_din)
  );

  int errs = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  // ---------------- reference model ----------------
  logic [7:0] exp_mem [64];
  int         t = -1;
  bit         m_rd;
  logic [5:0] m_a;
  logic [7:0] m_d;
  bit         m_rsp = 1'b0;
  logic [7:0] m_rdata = '0;

  initial for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);

  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1;
      m_rsp = 1'b0;
    end else if (t == -1) begin
      m_rsp = 1'b0;
      if (req_valid) begin
        m_rd = !req_write;
        m_a  = req_addr;
        m_d  = req_wdata;
        m_rdata = m_rd ? exp_mem[req_addr] : 8'h00;
        if (!m_rd) exp_mem[req_addr] = req_wdata;
        t = 0;
      end
    end else if (t == FRAME - 1) begin
      t = -1;
      m_rsp = 1'b1;
    end else begin
      t = t + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_en, e_clk, e_do, e_oe;
      if (t == -1) begin
        e_en = 0; e_clk = 0; e_do = 0; e_oe = 1;
        chk(req_ready == 1'b1, "R1", "ready idle", int'(req_ready), 1);
        chk(rsp_valid == m_rsp, "R9", "rsp_valid", int'(rsp_valid), int'(m_rsp));
        if (m_rsp)
          chk(rsp_rdata == m_rdata, "R6", "rsp_rdata", int'(rsp_rdata), int'(m_rdata));
      end else begin
        chk(req_ready == 1'b0, "R2", "ready busy", int'(req_ready), 0);
        chk(rsp_valid == 1'b0, "R9", "rsp busy", int'(rsp_valid), 0);
        if (t < 16 * P) begin
          int b, r;
          b = t / P;
          r = t % P;
          e_en  = 1;
          e_clk = (r >= S) && (r < S + H);
          e_oe  = !(m_rd && b >= 7);
          if (b < 6) e_do = m_a[5 - b];
          else if (b == 6) e_do = m_rd;
          else if (b == 7) e_do = 0;
          else e_do = m_rd ? 1'b0 : m_d[15 - b];
        end else begin
          e_en = 0; e_clk = 0; e_do = 0; e_oe = 1;
        end
      end
      chk(ser_en == e_en, (t >= 16 * P) ? "R8" : "R7", "ser_en", int'(ser_en), int'(e_en));
      chk(ser_clk == e_clk, "R7", "ser_clk", int'(ser_clk), int'(e_clk));
      chk(ser_doe == e_oe, "R4", "ser_doe", int'(ser_doe), int'(e_oe));
      chk(ser_dout == e_do, (t >= 0 && t < 6 * P) ? "R3" : "R5", "ser_dout",
          int'(ser_dout), int'(e_do));
    end
  end

  // ---------------- serial slave model ----------------
  logic [7:0] sl_mem [64];
  int         pc;
  logic [5:0] sl_a;
  bit         sl_rd;
  logic [7:0] sl_w;

  initial for (int i = 0; i < 64; i++) sl_mem[i] = init_val(i);

  always @(posedge ser_en) begin
    pc = 0;
    ser_din = 1'b0;
  end

  always @(posedge ser_clk) begin
    if (pc < 6) sl_a = {sl_a[4:0], ser_dout};
    else if (pc == 6) sl_rd = ser_dout;
    else if (pc >= 8) begin
      if (sl_rd) chk(ser_doe == 1'b0, "R4", "doe while slave drives", int'(ser_doe), 0);
      else sl_w = {sl_w[6:0], ser_dout};
    end
    pc = pc + 1;
  end

  always @(negedge ser_clk) begin
    if (pc >= 8 && pc <= 15 && sl_rd) ser_din = sl_mem[sl_a][15 - pc];
  end

  always @(negedge ser_en) begin
    if (rst_n) begin
      chk(pc == 16, "R7", "pulses per frame", pc, 16);
      chk(sl_a == m_a, "R3", "address seen", int'(sl_a), int'(m_a));
      chk(sl_rd == m_rd, "R3", "direction seen", int'(sl_rd), int'(m_rd));
      if (!sl_rd) begin
        chk(sl_w == m_d, "R5", "write byte seen", int'(sl_w), int'(m_d));
        sl_mem[sl_a] = sl_w;
      end
      ser_din = 1'b0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit wr, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    do @(negedge clk); while (!rsp_valid);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ser_en == 1'b0, "R1", "reset en", int'(ser_en), 0);
    chk(ser_clk == 1'b0, "R1", "reset clk", int'(ser_clk), 0);
    chk(ser_doe == 1'b1 && ser_dout == 1'b0, "R1", "reset data pad",
        int'({ser_doe, ser_dout}), 2);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "reset handshake",
        int'({req_ready, rsp_valid}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    send(1'b1, 6'h00, 8'h55); wait_rsp();          // R5 write
    send(1'b0, 6'h00, 8'h00); wait_rsp();          // R6 read back 0x55
    chk(rsp_rdata == 8'h55, "R6", "readback 0x55", int'(rsp_rdata), 8'h55);
    send(1'b0, 6'h3F, 8'hFF); wait_rsp();          // R3 all-ones address
    chk(rsp_rdata == init_val(63), "R6", "read 0x3F", int'(rsp_rdata), int'(init_val(63)));

    // R2: stray request held during a busy frame
    send(1'b1, 6'h2A, 8'hC3);
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h11; req_wdata = 8'h00;
    repeat (300) @(negedge clk);
    req_valid = 1'b0;
    wait_rsp();
    send(1'b0, 6'h11, 8'h00); wait_rsp();
    chk(rsp_rdata == init_val(17), "R2", "stray ignored", int'(rsp_rdata), int'(init_val(17)));

    // R9: back-to-back, next request accepted in the response cycle
    send(1'b1, 6'h15, 8'h9A);
    send(1'b0, 6'h15, 8'h00);
    chk(ser_en == 1'b1, "R9", "second frame started", int'(ser_en), 1);
    send(1'b0, 6'h2A, 8'h00);
    wait_rsp();
    chk(rsp_rdata == 8'hC3, "R6", "read 0x2A", int'(rsp_rdata), 8'hC3);
    repeat (5) @(negedge clk);
    done_flag = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule